// File: doc/BRIEF.md
# Mixed-Polarity Interrupt Flag Aggregator

This block merges a bank of FIFO level indicators and a few event lines into one level-sensitive interrupt request. The indicators have different active levels. Full, almost-full and half-full style indicators request service when they read 0. Empty and almost-empty style indicators request service when they read 1, which means the FIFO holds data. The block turns every input into a common "1 means request" form, gates each one with a per-bit enable from software, and then applies a global enable. The result is registered onto `irq_o`.

Software reaches the block over a narrow longword register port. The port has a word index, a write strobe, write data and combinational read data. There are two enable registers, two read-only indicator registers and a control register. The control register holds a level-type clear for a sticky overflow latch and a selector for how the indicator registers read back. In raw mode the registers show the input levels as they arrive. In masked mode, a bit whose enable is 0 reads at its idle level. A separate input reports whether an optional add-on module is attached. It can be read but never requests service.

Top module: `irq_flag_aggregator`

## Requirements
- R1: After reset the control word reads 0x0000_0085, both enable words read 0, and `irq_o` is 0.
- R2: The word index selects the registers as follows: 0 control, 1 enable word A, 2 enable word B, 3 indicator word A, 4 indicator word B, and 5 to 7 read 0. Writes to indices 3 to 7 change nothing. Enable bits with no source behind them read 0.
- R3: The active-low indicators sit at bits [N_LOW-1:0] of indicator word A and enable word A. Each one requests service when its input is 0.
- R4: The active-high indicators sit at bits [N_HIGH-1:0] of indicator word B and enable word B. Each one requests service when its input is 1.
- R5: An enable bit of 0 suppresses its source and 1 passes it. Bit 31 of enable word A is the global enable, and while it is 0 `irq_o` stays 0.
- R6: The add-on module's interrupt line (bit 29 of word A) and the collector-done event (bit 29 of word B) are active high. Each has its own enable bit at the same position.
- R7: The add-on presence input reads at bit 30 of indicator word B in both read-back modes and never raises `irq_o`.
- R8: The overflow latch reads at bit 30 of indicator word A and is enabled by bit 30 of enable word A. It sets on a one-cycle `ovf_pulse`. It holds until the cycle after control bit 0 is 1. If set and clear meet in the same cycle, the latch stays set.
- R9: Control bit 24 selects the read-back mode. With 0, the indicator words show raw levels. With 1, every bit whose enable is 0 reads at its idle level: 1 for active-low indicators and 0 for the rest.
- R10: `irq_o` follows a change of inputs or enables exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| low_lvl_flags | input | N_LOW | Indicators that request service at 0 |
| high_lvl_flags | input | N_HIGH | Indicators that request service at 1 |
| ext_irq_in | input | 1 | Interrupt line from the optional module |
| done_evt | input | 1 | Collector completion event |
| ext_present | input | 1 | Optional module attached |
| ovf_pulse | input | 1 | One-cycle overflow event |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The bench walks a single asserted indicator across every active-low and active-high position. It drives each one with its enable on and then with its enable off. A design with a polarity inverted on one bit, or with an off-by-one enable position, raises or drops `irq_o` at the wrong step. The overflow latch is hit with set and clear in the same cycle. A design where clear wins loses the event, and one that treats clear as a pulse keeps the latch stuck after the clear. Masked read-back is compared bit by bit with partial enables. This catches idle levels of the wrong polarity and a presence bit that gets masked.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_MASK_A = 3'd1,
    REG_MASK_B = 3'd2,
    REG_FLAG_A = 3'd3,
    REG_FLAG_B = 3'd4
  } reg_idx_e;

  localparam int unsigned MASTER_BIT = 31;
  localparam int unsigned OVF_BIT    = 30;
  localparam int unsigned EXT_BIT    = 29;
  localparam int unsigned DONE_BIT   = 29;
  localparam int unsigned PRES_BIT   = 30;

  // Flip active-low positions so that 1 always means "request".
  function automatic word_t to_active(word_t raw, word_t low_map);
    return raw ^ low_map;
  endfunction

  // Keep bits selected by keep; others show their idle level.
  function automatic word_t masked_view(word_t raw, word_t keep, word_t low_map);
    return (raw & keep) | (low_map & ~keep);
  endfunction

  function automatic logic any_request(word_t act, word_t en);
    return |(act & en);
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter word_t CTRL_RESET   = 32'h0000_0085,
  parameter word_t MASK_A_VALID = '1,
  parameter word_t MASK_B_VALID = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  word_t      wr_data,
  output word_t      ctrl_q,
  output word_t      mask_a_q,
  output word_t      mask_b_q
);
  logic wr_ctrl, wr_ma, wr_mb;
  assign wr_ctrl = wr_en && (wr_idx == REG_CTRL);
  assign wr_ma   = wr_en && (wr_idx == REG_MASK_A);
  assign wr_mb   = wr_en && (wr_idx == REG_MASK_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= wr_data;
      if (wr_ma)   mask_a_q <= wr_data & MASK_A_VALID;
      if (wr_mb)   mask_b_q <= wr_data & MASK_B_VALID;
    end
  end

  // R2: enables change only on a write to their own index
  assert_mask_a_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ma |=> $stable(mask_a_q));
  assert_mask_b_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mb |=> $stable(mask_b_q));
  assert_mask_unsourced_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_a_q & ~MASK_A_VALID) == '0) && ((mask_b_q & ~MASK_B_VALID) == '0));
endmodule

// File: rtl/irq_agg_ovf.sv
module irq_agg_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_level,
  output logic ovf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (set_pulse) ovf_q <= 1'b1;
    else if (clr_level) ovf_q <= 1'b0;
  end

  // R8: set has priority, latch holds, clear level empties it
  assert_ovf_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> ovf_q);
  assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_level) |=> ovf_q);
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_level && !set_pulse) |=> !ovf_q);
endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_LOW  = 22,
  parameter int unsigned N_HIGH = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LOW-1:0]  low_flags,
  input  logic [N_HIGH-1:0] high_flags,
  input  logic              ext_irq,
  input  logic              done_evt,
  input  logic              present,
  input  logic              ovf_q,
  input  word_t             mask_a,
  input  word_t             mask_b,
  input  logic              readback_masked,
  output word_t             flag_a_rd,
  output word_t             flag_b_rd,
  output logic              req_any,
  output logic              irq_q
);
  localparam word_t LOW_MAP_A  = word_t'((64'd1 << N_LOW) - 64'd1);
  localparam word_t HIGH_MAP_B = word_t'((64'd1 << N_HIGH) - 64'd1);
  localparam word_t SRC_MAP_B  = HIGH_MAP_B | (word_t'(1) << DONE_BIT);
  localparam word_t PRES_MAP   = word_t'(1) << PRES_BIT;

  word_t raw_a, raw_b, act_a, act_b;
  logic  master_en;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_raw
      if (i < N_LOW)         begin : g_a_low  assign raw_a[i] = low_flags[i]; end
      else if (i == OVF_BIT) begin : g_a_ovf  assign raw_a[i] = ovf_q;        end
      else if (i == EXT_BIT) begin : g_a_ext  assign raw_a[i] = ext_irq;      end
      else                   begin : g_a_zero assign raw_a[i] = 1'b0;         end
      if (i < N_HIGH)         begin : g_b_high assign raw_b[i] = high_flags[i]; end
      else if (i == DONE_BIT) begin : g_b_done assign raw_b[i] = done_evt;      end
      else if (i == PRES_BIT) begin : g_b_pres assign raw_b[i] = present;       end
      else                    begin : g_b_zero assign raw_b[i] = 1'b0;          end
    end
  endgenerate

  assign master_en = mask_a[MASTER_BIT];
  assign act_a     = to_active(raw_a, LOW_MAP_A);
  assign act_b     = to_active(raw_b, '0);
  assign req_any   = any_request(act_a, mask_a) || any_request(act_b, mask_b & SRC_MAP_B);

  assign flag_a_rd = readback_masked ? masked_view(raw_a, mask_a, LOW_MAP_A) : raw_a;
  assign flag_b_rd = readback_masked ? masked_view(raw_b, mask_b | PRES_MAP, '0) : raw_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= master_en && req_any;
  end

  // R5: global enable off blocks the output
  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !irq_q);
  // R10: a pending enabled request shows one clock later
  assert_irq_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && req_any) |=> irq_q);
  // R7: presence bit is visible in both modes
  assert_presence_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_b_rd[PRES_BIT] == present);
endmodule

// File: rtl/irq_flag_aggregator.sv
module irq_flag_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_LOW      = 22,
  parameter int unsigned N_HIGH     = 29,
  parameter word_t       CTRL_RESET = 32'h0000_0085,
  parameter int unsigned CLR_BIT    = 0,
  parameter int unsigned MODE_BIT   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_LOW-1:0]  low_lvl_flags,
  input  logic [N_HIGH-1:0] high_lvl_flags,
  input  logic              ext_irq_in,
  input  logic              done_evt,
  input  logic              ext_present,
  input  logic              ovf_pulse,
  output logic              irq_o
);
  localparam word_t LOW_MAP   = word_t'((64'd1 << N_LOW) - 64'd1);
  localparam word_t HIGH_MAP  = word_t'((64'd1 << N_HIGH) - 64'd1);
  localparam word_t MA_VALID  = LOW_MAP | (word_t'(1) << MASTER_BIT)
                              | (word_t'(1) << OVF_BIT) | (word_t'(1) << EXT_BIT);
  localparam word_t MB_VALID  = HIGH_MAP | (word_t'(1) << DONE_BIT);

  word_t ctrl_q, mask_a_q, mask_b_q, flag_a_rd, flag_b_rd;
  logic  ovf_q, req_any, irq_q;

  irq_agg_regs #(
    .CTRL_RESET  (CTRL_RESET),
    .MASK_A_VALID(MA_VALID),
    .MASK_B_VALID(MB_VALID)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .wr_idx  (bus_addr),
    .wr_data (bus_wdata),
    .ctrl_q  (ctrl_q),
    .mask_a_q(mask_a_q),
    .mask_b_q(mask_b_q)
  );

  irq_agg_ovf ovf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse(ovf_pulse),
    .clr_level(ctrl_q[CLR_BIT]),
    .ovf_q    (ovf_q)
  );

  irq_agg_combine #(
    .N_LOW (N_LOW),
    .N_HIGH(N_HIGH)
  ) comb_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .low_flags      (low_lvl_flags),
    .high_flags     (high_lvl_flags),
    .ext_irq        (ext_irq_in),
    .done_evt       (done_evt),
    .present        (ext_present),
    .ovf_q          (ovf_q),
    .mask_a         (mask_a_q),
    .mask_b         (mask_b_q),
    .readback_masked(ctrl_q[MODE_BIT]),
    .flag_a_rd      (flag_a_rd),
    .flag_b_rd      (flag_b_rd),
    .req_any        (req_any),
    .irq_q          (irq_q)
  );

  assign irq_o = irq_q;

  always_comb begin
    case (bus_addr)
      REG_CTRL:   bus_rdata = ctrl_q;
      REG_MASK_A: bus_rdata = mask_a_q;
      REG_MASK_B: bus_rdata = mask_b_q;
      REG_FLAG_A: bus_rdata = flag_a_rd;
      REG_FLAG_B: bus_rdata = flag_b_rd;
      default:    bus_rdata = '0;
    endcase
  end

  // R8: the latch is visible at its indicator position in raw mode
  assert_ovf_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_FLAG_A && !ctrl_q[MODE_BIT]) |-> (bus_rdata[OVF_BIT] == ovf_q));
  // R1/R10: output stays low until something has been enabled
  assert_no_irq_without_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_a_q) == '0 && $past(mask_b_q) == '0) |-> !irq_o);
endmodule

// File: tb/irq_flag_aggregator_tb.sv
`timescale 1ns/1ps
module irq_flag_aggregator_tb_top;
  localparam int NL = 22;
  localparam int NH = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] low_f = '1;
  logic [NH-1:0] high_f = '0;
  logic          ext_i = 1'b0, done_i = 1'b0, pres_i = 1'b0, ovf_p = 1'b0;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_flag_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .low_lvl_flags(low_f),
    .high_lvl_flags(high_f), .ext_irq_in(ext_i), .done_evt(done_i),
    .ext_present(pres_i), .ovf_pulse(ovf_p), .irq_o(irq)
  );

  localparam logic [31:0] LMAP = (32'd1 << NL) - 32'd1;
  localparam logic [31:0] HMAP = (32'd1 << NH) - 32'd1;
  localparam logic [31:0] MA_ALL = LMAP | 32'hE000_0000;
  localparam logic [31:0] MB_ALL = HMAP | 32'h2000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = idx; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
    bus_addr = idx;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // Expected indicator words built bit by bit from the requirements
  function automatic logic [31:0] exp_a(input bit masked, input logic [31:0] m, input bit ovf);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic v;
      logic idle;
      v = 1'b0; idle = 1'b0;
      if (i < NL) begin v = low_f[i]; idle = 1'b1; end
      else if (i == 30) v = ovf;
      else if (i == 29) v = ext_i;
      r[i] = (masked && !m[i] && i != 31) ? idle : v;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_b(input bit masked, input logic [31:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic v;
      v = 1'b0;
      if (i < NH) v = high_f[i];
      else if (i == 29) v = done_i;
      else if (i == 30) v = pres_i;
      r[i] = (masked && !m[i] && i != 30) ? 1'b0 : v;
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset values
    rd_chk("R1 ctrl", 3'd0, 32'h0000_0085);
    rd_chk("R1 maskA", 3'd1, 32'h0);
    rd_chk("R1 maskB", 3'd2, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 map, unsourced bits, read-only and unused indices
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk("R2 maskA sourced bits", 3'd1, MA_ALL);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk("R2 maskB sourced bits", 3'd2, MB_ALL);
    for (int k = 3; k < 8; k++) wr(3'(k), 32'hA5A5_A5A5);
    rd_chk("R2 ctrl untouched", 3'd0, 32'h0000_0085);
    rd_chk("R2 maskA untouched", 3'd1, MA_ALL);
    rd_chk("R2 raw flagA", 3'd3, exp_a(0, MA_ALL, 0));
    for (int k = 5; k < 8; k++) rd_chk("R2 unused index", 3'(k), 32'h0);
    step();
    chk("R5 idle inputs no irq", {31'd0, irq}, 32'd0);

    // R3 sweep of active-low indicators
    for (int i = 0; i < NL; i++) begin
      wr(3'd1, MA_ALL);
      low_f = ~(NL'(1) << i);
      step();
      chk($sformatf("R3 low bit %0d enabled", i), {31'd0, irq}, 32'd1);
      rd_chk($sformatf("R3 raw read bit %0d", i), 3'd3, exp_a(0, MA_ALL, 0));
      wr(3'd1, MA_ALL & ~(32'd1 << i));
      step();
      chk($sformatf("R5 low bit %0d masked", i), {31'd0, irq}, 32'd0);
      low_f = '1;
    end

    // R4 sweep of active-high indicators
    wr(3'd1, 32'h8000_0000);
    for (int i = 0; i < NH; i++) begin
      wr(3'd2, MB_ALL);
      high_f = NH'(1) << i;
      step();
      chk($sformatf("R4 high bit %0d enabled", i), {31'd0, irq}, 32'd1);
      rd_chk($sformatf("R4 raw read bit %0d", i), 3'd4, exp_b(0, MB_ALL));
      wr(3'd2, MB_ALL & ~(32'd1 << i));
      step();
      chk($sformatf("R5 high bit %0d masked", i), {31'd0, irq}, 32'd0);
      high_f = '0;
    end

    // R5 global enable
    wr(3'd2, MB_ALL);
    high_f = '1;
    wr(3'd1, MA_ALL & ~32'h8000_0000);
    step();
    chk("R5 global enable off", {31'd0, irq}, 32'd0);
    high_f = '0;

    // R6 add-on line and done event
    wr(3'd1, 32'hA000_0000);
    wr(3'd2, 32'h0);
    ext_i = 1'b1; step();
    chk("R6 ext irq enabled", {31'd0, irq}, 32'd1);
    rd_chk("R6 ext visible", 3'd3, exp_a(0, 32'hA000_0000, 0));
    wr(3'd1, 32'h8000_0000); step();
    chk("R6 ext irq masked", {31'd0, irq}, 32'd0);
    ext_i = 1'b0; done_i = 1'b1;
    wr(3'd2, 32'h2000_0000); step();
    chk("R6 done enabled", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h0); step();
    chk("R6 done masked", {31'd0, irq}, 32'd0);
    done_i = 1'b0;

    // R7 presence never interrupts
    wr(3'd1, MA_ALL); wr(3'd2, 32'hFFFF_FFFF);
    pres_i = 1'b1; step(); step();
    chk("R7 presence no irq", {31'd0, irq}, 32'd0);
    rd_chk("R7 presence raw", 3'd4, exp_b(0, MB_ALL));

    // R8 overflow latch
    wr(3'd1, 32'hC000_0000);
    wr(3'd0, 32'h0000_0084);
    rd_chk("R8 ovf idle", 3'd3, exp_a(0, 32'hC000_0000, 0));
    @(negedge clk); ovf_p = 1'b1;
    @(negedge clk); ovf_p = 1'b0;
    rd_chk("R8 ovf set", 3'd3, exp_a(0, 32'hC000_0000, 1));
    step();
    chk("R8 ovf interrupts", {31'd0, irq}, 32'd1);
    repeat (5) step();
    rd_chk("R8 ovf held", 3'd3, exp_a(0, 32'hC000_0000, 1));
    wr(3'd0, 32'h0000_0085);
    step();
    rd_chk("R8 ovf cleared", 3'd3, exp_a(0, 32'hC000_0000, 0));
    @(negedge clk); ovf_p = 1'b1;
    @(negedge clk); ovf_p = 1'b0;
    rd_chk("R8 set wins over clear", 3'd3, exp_a(0, 32'hC000_0000, 1));
    step();
    rd_chk("R8 clear after set", 3'd3, exp_a(0, 32'hC000_0000, 0));
    wr(3'd0, 32'h0000_0084);

    // R9 masked read-back
    low_f = '0; high_f = '1; ext_i = 1'b1; done_i = 1'b1;
    wr(3'd1, 32'h8000_0003);
    wr(3'd2, 32'h0000_0005);
    wr(3'd0, 32'h0100_0084);
    rd_chk("R9 masked word A", 3'd3, exp_a(1, 32'h8000_0003, 0));
    rd_chk("R9 masked word B", 3'd4, exp_b(1, 32'h0000_0005));
    wr(3'd0, 32'h0000_0084);
    rd_chk("R9 raw word A", 3'd3, exp_a(0, 32'h8000_0003, 0));
    rd_chk("R9 raw word B", 3'd4, exp_b(0, 32'h0000_0005));

    // R10 one clock latency
    low_f = '1; high_f = '0; ext_i = 1'b0; done_i = 1'b0;
    wr(3'd1, MA_ALL); wr(3'd2, MB_ALL);
    step();
    @(negedge clk); high_f[3] = 1'b1;
    #1 chk("R10 not before edge", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 after one edge", {31'd0, irq}, 32'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule